// File: doc/BRIEF.md
# Transmit Collision and Defer Statistics

This block keeps the transmit-side collision and deferral statistics of an Ethernet MAC. When a transmit attempt completes, the transmit engine hands the block one report over a valid/ready channel. The report carries:

- the number of collisions the frame saw;
- a late-collision flag, a deferral flag, a carrier-seen flag and a success flag;
- the duplex mode in force;
- a flag that marks the frame as a flow-control frame.

From each accepted report the block updates seven saturating counters. Software reads them through a simple read port. A read can optionally clear the counter it reads.

The report channel never back-pressures once reset is released. `rpt_ready` is low while `rst_n` is low and high from the first clock edge after reset onward. A report is taken on each rising edge where `rpt_valid` and `rpt_ready` are both high. A producer may therefore present back-to-back reports, one per cycle.

Top module: `tx_coll_stats`

## Requirements
- R1: In half duplex (`rpt_full_duplex`=0), a report with a collision count of exactly 1 adds one to counter 0 (single collision).
- R2: In half duplex, a report with a collision count from 2 to 15 inclusive adds one to counter 1 (multiple collision).
- R3: In half duplex, a report with a collision count of 16 or more adds one to counter 2 (excessive collision). The collision count is a 5-bit unsigned field.
- R4: In half duplex, a report with `rpt_late`=1 (collision after 64 byte times) adds one to counter 3 (late collision), independent of the collision count.
- R5: In half duplex, counter 4 (total collisions) adds the report's full collision count.
- R6: In full duplex, reports leave counters 0 through 4 unchanged, whatever their collision count or late flag.
- R7: A report with `rpt_deferred`=1 adds one to counter 5 (defer) in either duplex mode.
- R8: Counter 6 (no carrier sense) adds one only when all of the following hold: full duplex, `rpt_success`=1, `rpt_crs_seen`=0 and `rpt_flow_ctl`=0.
- R9: Every counter is 16 bits wide. It saturates at 16'hFFFF and never wraps.
- R10: A read pulse (`rd_en`) returns the counter selected by `rd_addr` on `rd_data` in the next cycle. Addresses 7 and above return zero.
- R11: A read with `rd_clear`=1 returns the old value and zeroes that counter. If a report increments the same counter in that same cycle, the counter is left holding the increment, so the event is not lost.
- R12: Reset zeroes every counter and `rd_data` and holds `rpt_ready` low. A report counts only on a valid-and-ready edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | Completion report valid |
| rpt_ready | output | 1 | Block accepts a report |
| rpt_coll_num | input | 5 | Collisions seen by the frame |
| rpt_late | input | 1 | A late collision occurred |
| rpt_deferred | input | 1 | The frame had to wait (busy medium or link down) |
| rpt_crs_seen | input | 1 | Carrier sense seen within one slot time |
| rpt_success | input | 1 | The frame was sent successfully |
| rpt_full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| rpt_flow_ctl | input | 1 | The frame is a flow-control frame |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Counter index |
| rd_clear | input | 1 | Clear the counter being read |
| rd_data | output | 16 | Read result, valid the cycle after `rd_en` |

## Verification
Each counter's state reaches the ports only through the read port. A wrong counter therefore shows up one cycle after the read that selects it, and it stays wrong until it is cleared or reset.

- **Wrong classification.** Misplaced collision boundaries, missing duplex gating or a missing flow-control exclusion leave a counter off by one per offending report. The bench reads every counter after each scenario, so it catches the error at the end of that scenario.
- **Wrong saturation or clear logic.** These errors only appear at the limits. The bench drives the total counter into saturation, and it reads with clear in the same cycle as an increment.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  parameter int COLL_W  = 5;   // width of the collision count field
  parameter int CNT_W   = 16;  // width of each statistics counter
  parameter int NCNT    = 7;   // number of counters
  parameter int ADDR_W  = 3;
  parameter int EXC_LIM = 16;  // collisions at which a frame is excessive

  // counter indices, also their read addresses
  parameter int IDX_SINGLE = 0;
  parameter int IDX_MULTI  = 1;
  parameter int IDX_EXCESS = 2;
  parameter int IDX_LATE   = 3;
  parameter int IDX_TOTAL  = 4;
  parameter int IDX_DEFER  = 5;
  parameter int IDX_NOCRS  = 6;

  typedef struct packed {
    logic [COLL_W-1:0] coll_num;
    logic              late;
    logic              deferred;
    logic              crs_seen;
    logic              success;
    logic              full_duplex;
    logic              flow_ctl;
  } tx_report_t;
endpackage

// File: rtl/tcs_classify.sv
module tcs_classify
  import tcs_pkg::*;
#(
  parameter int CW = COLL_W,
  parameter int N  = NCNT
) (
  input  logic          take,
  input  tx_report_t    rpt,
  output logic [N*CW-1:0] amt_flat
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ELIM = CW'(EXC_LIM);

  logic half;
  logic is_single, is_multi, is_excess;

  always_comb begin
    half      = take && !rpt.full_duplex;
    is_single = rpt.coll_num == ONE;
    is_multi  = (rpt.coll_num > ONE) && (rpt.coll_num < ELIM);
    is_excess = rpt.coll_num >= ELIM;
    amt_flat  = '0;
    amt_flat[IDX_SINGLE*CW +: CW] = (half && is_single) ? ONE : ZERO;
    amt_flat[IDX_MULTI*CW  +: CW] = (half && is_multi)  ? ONE : ZERO;
    amt_flat[IDX_EXCESS*CW +: CW] = (half && is_excess) ? ONE : ZERO;
    amt_flat[IDX_LATE*CW   +: CW] = (half && rpt.late)  ? ONE : ZERO;
    amt_flat[IDX_TOTAL*CW  +: CW] = half ? rpt.coll_num : ZERO;
    amt_flat[IDX_DEFER*CW  +: CW] = (take && rpt.deferred) ? ONE : ZERO;
    amt_flat[IDX_NOCRS*CW  +: CW] =
      (take && rpt.full_duplex && rpt.success && !rpt.crs_seen && !rpt.flow_ctl)
        ? ONE : ZERO;
  end
endmodule

// File: rtl/tcs_counter.sv
module tcs_counter #(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] amt,
  input  logic          clr,
  output logic [W-1:0]  value
);
  logic [W-1:0] base;
  logic [W:0]   sum;

  always_comb begin
    base = clr ? '0 : value;
    sum  = {1'b0, base} + (W+1)'(amt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      value <= '0;
    else if (sum[W])
      value <= '1;
    else
      value <= sum[W-1:0];
  end
endmodule

// File: rtl/tx_coll_stats.sv
module tx_coll_stats
  import tcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_valid,
  output logic              rpt_ready,
  input  logic [COLL_W-1:0] rpt_coll_num,
  input  logic              rpt_late,
  input  logic              rpt_deferred,
  input  logic              rpt_crs_seen,
  input  logic              rpt_success,
  input  logic              rpt_full_duplex,
  input  logic              rpt_flow_ctl,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_clear,
  output logic [CNT_W-1:0]  rd_data
);
  tx_report_t              rpt;
  logic                    take;
  logic [NCNT*COLL_W-1:0]  amt_flat;
  logic [NCNT*CNT_W-1:0]   cnt_flat;
  logic [NCNT-1:0]         clr_vec;
  logic [CNT_W-1:0]        rd_sel;

  always_comb begin
    rpt.coll_num    = rpt_coll_num;
    rpt.late        = rpt_late;
    rpt.deferred    = rpt_deferred;
    rpt.crs_seen    = rpt_crs_seen;
    rpt.success     = rpt_success;
    rpt.full_duplex = rpt_full_duplex;
    rpt.flow_ctl    = rpt_flow_ctl;
    take            = rpt_valid && rpt_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rpt_ready <= 1'b0;
    else        rpt_ready <= 1'b1;
  end

  tcs_classify #(.CW(COLL_W), .N(NCNT)) u_cls (
    .take     (take),
    .rpt      (rpt),
    .amt_flat (amt_flat)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign clr_vec[i] = rd_en && rd_clear && (rd_addr == ADDR_W'(i));
    tcs_counter #(.W(CNT_W), .AW(COLL_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .amt   (amt_flat[i*COLL_W +: COLL_W]),
      .clr   (clr_vec[i]),
      .value (cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCNT; i++)
      if (rd_addr == ADDR_W'(i)) rd_sel = cnt_flat[i*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
  import tcs_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   take,
  input logic                   rpt_ready,
  input logic                   full_duplex,
  input logic                   rd_en,
  input logic                   rd_clear,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [CNT_W-1:0]       rd_data,
  input logic [NCNT*CNT_W-1:0]  cnt_flat,
  input logic [NCNT*COLL_W-1:0] amt_flat
);
  logic [CNT_W-1:0] peek;
  logic [CNT_W-1:0] total_c, single_c;
  logic             any_clr;

  always_comb begin
    peek = '0;
    for (int i = 0; i < NCNT; i++)
      if (rd_addr == ADDR_W'(i)) peek = cnt_flat[i*CNT_W +: CNT_W];
    total_c  = cnt_flat[IDX_TOTAL*CNT_W +: CNT_W];
    single_c = cnt_flat[IDX_SINGLE*CNT_W +: CNT_W];
    any_clr  = rd_en && rd_clear;
  end

  // R1 R2 R3: the three collision classes are mutually exclusive
  assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({amt_flat[IDX_SINGLE*COLL_W], amt_flat[IDX_MULTI*COLL_W],
              amt_flat[IDX_EXCESS*COLL_W]}));

  assert_full_duplex_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full_duplex && !any_clr) |=> (single_c == $past(single_c)));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (total_c == '1 && !any_clr) |=> (total_c == '1));

  assert_read_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data == $past(peek)));

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !rd_en) |=> $stable(cnt_flat));
endmodule

bind tx_coll_stats tcs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .take        (take),
  .rpt_ready   (rpt_ready),
  .full_duplex (rpt_full_duplex),
  .rd_en       (rd_en),
  .rd_clear    (rd_clear),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .cnt_flat    (cnt_flat),
  .amt_flat    (amt_flat)
);

// File: tb/sim_tx_coll_stats.sv
module sim_tx_coll_stats;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rpt_valid = 1'b0;
  logic        rpt_ready;
  logic [4:0]  rpt_coll_num = '0;
  logic        rpt_late = 1'b0, rpt_deferred = 1'b0, rpt_crs_seen = 1'b0;
  logic        rpt_success = 1'b0, rpt_full_duplex = 1'b0, rpt_flow_ctl = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic        rd_clear = 1'b0;
  logic [15:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  int exp_c [7];
  string tag [7] = '{"R1", "R2", "R3", "R4", "R5", "R7", "R8"};

  always #10 clk = ~clk;

  tx_coll_stats u0 (.*);

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R12: actual hung expected done");
    finish_run();
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat_add(int a, int b);
    return (a + b > 65535) ? 65535 : a + b;
  endfunction

  // reference model from the requirements
  task automatic model(int c, bit late, bit dfr, bit crs, bit ok, bit fd, bit fc);
    if (!fd) begin
      if (c == 1) exp_c[0] = sat_add(exp_c[0], 1);                  // R1
      if (c >= 2 && c <= 15) exp_c[1] = sat_add(exp_c[1], 1);       // R2
      if (c >= 16) exp_c[2] = sat_add(exp_c[2], 1);                 // R3
      if (late) exp_c[3] = sat_add(exp_c[3], 1);                    // R4
      exp_c[4] = sat_add(exp_c[4], c);                              // R5
    end
    if (dfr) exp_c[5] = sat_add(exp_c[5], 1);                       // R7
    if (fd && ok && !crs && !fc) exp_c[6] = sat_add(exp_c[6], 1);   // R8
  endtask

  task automatic drive(int c, bit late, bit dfr, bit crs, bit ok, bit fd, bit fc);
    rpt_valid = 1'b1; rpt_coll_num = 5'(c); rpt_late = late; rpt_deferred = dfr;
    rpt_crs_seen = crs; rpt_success = ok; rpt_full_duplex = fd; rpt_flow_ctl = fc;
    model(c, late, dfr, crs, ok, fd, fc);
  endtask

  task automatic send(int c, bit late, bit dfr, bit crs, bit ok, bit fd, bit fc);
    @(negedge clk);
    drive(c, late, dfr, crs, ok, fd, fc);
    @(negedge clk);
    rpt_valid = 1'b0;
  endtask

  task automatic rd(int addr, bit clr, output int val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'(addr); rd_clear = clr;
    @(negedge clk);
    rd_en = 1'b0; rd_clear = 1'b0;
    val = int'(rd_data);
  endtask

  task automatic check_all(string why);
    int v;
    for (int i = 0; i < 7; i++) begin
      rd(i, 1'b0, v);
      check($sformatf("%s %s cnt%0d", tag[i], why, i), v, exp_c[i]);
    end
  endtask

  task automatic t_reset();
    int v;
    check("R12 ready low in reset", int'(rpt_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R12 ready after reset", int'(rpt_ready), 1);
    for (int i = 0; i < 7; i++) begin
      rd(i, 1'b0, v);
      check("R12 reset value", v, 0);
    end
  endtask

  task automatic t_not_accepted();
    @(negedge clk);
    rpt_coll_num = 5'd1; rpt_full_duplex = 1'b0; rpt_deferred = 1'b1;
    @(negedge clk);   // valid stays low: nothing counts
    check_all("no valid R12");
  endtask

  task automatic t_half_classes();
    send(0, 0, 0, 0, 1, 0, 0);
    send(1, 0, 0, 0, 1, 0, 0);
    send(2, 0, 0, 0, 1, 0, 0);
    send(15, 0, 0, 0, 1, 0, 0);
    send(16, 0, 0, 0, 0, 0, 0);
    send(31, 0, 0, 0, 0, 0, 0);
    send(3, 1, 0, 0, 1, 0, 0);
    send(0, 1, 0, 0, 1, 0, 0);
    check_all("half duplex classes");
  endtask

  task automatic t_full_duplex();
    send(1, 1, 0, 1, 1, 1, 0);
    send(9, 1, 0, 1, 1, 1, 0);
    send(20, 0, 0, 1, 0, 1, 0);
    check_all("full duplex gating R6");
  endtask

  task automatic t_defer();
    send(0, 0, 1, 1, 1, 0, 0);
    send(0, 0, 1, 1, 1, 1, 0);
    check_all("defer");
  endtask

  task automatic t_nocrs();
    send(0, 0, 0, 0, 1, 1, 0);   // counts
    send(0, 0, 0, 1, 1, 1, 0);   // carrier seen
    send(0, 0, 0, 0, 1, 0, 0);   // half duplex
    send(0, 0, 0, 0, 1, 1, 1);   // flow-control frame
    send(0, 0, 0, 0, 0, 1, 0);   // not successful
    check_all("no carrier");
  endtask

  task automatic t_back_to_back();
    @(negedge clk); drive(1, 0, 1, 0, 1, 0, 0);
    @(negedge clk); drive(4, 0, 0, 0, 1, 0, 0);
    @(negedge clk); drive(0, 0, 0, 0, 1, 1, 0);
    @(negedge clk); rpt_valid = 1'b0;
    check_all("back to back R12");
  endtask

  task automatic t_read_map();
    int v;
    rd(7, 1'b0, v);
    check("R10 address 7 reads zero", v, 0);
  endtask

  task automatic t_clear();
    int v;
    rd(4, 1'b1, v);
    check("R11 clear returns old", v, exp_c[4]);
    exp_c[4] = 0;
    rd(4, 1'b0, v);
    check("R11 cleared", v, 0);
    check_all("after clear R11");
  endtask

  task automatic t_clear_collide();
    int v;
    int old;
    old = exp_c[4];
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd4; rd_clear = 1'b1;
    drive(6, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    rpt_valid = 1'b0; rd_en = 1'b0; rd_clear = 1'b0;
    check("R11 collide returns old", int'(rd_data), old);
    exp_c[4] = 6;
    rd(4, 1'b0, v);
    check("R11 collide keeps increment", v, 6);
  endtask

  task automatic t_saturate();
    int v;
    @(negedge clk);
    for (int k = 0; k < 2200; k++) begin
      drive(31, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
    end
    rpt_valid = 1'b0;
    rd(4, 1'b0, v);
    check("R9 total saturates", v, 65535);
    send(31, 0, 0, 0, 0, 0, 0);
    rd(4, 1'b0, v);
    check("R9 stays at max", v, 65535);
    check_all("saturation R9");
  endtask

  initial begin
    for (int i = 0; i < 7; i++) exp_c[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_not_accepted();
    t_half_classes();
    t_full_duplex();
    t_defer();
    t_nocrs();
    t_back_to_back();
    t_read_map();
    t_clear();
    t_clear_collide();
    t_saturate();
    finish_run();
  end
endmodule